// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block sets the bit timing for an I2C master engine. A peripheral clock is divided by a programmable prescaler into an internal reference tick. Each SCL period then lasts a fixed base of 20 ticks, plus 8 ticks per step of a 6-bit divider, plus a small programmable count that covers the edge rise time, fall time and internal delay. Both divider fields are packed into one configuration word. The divider step sits above the prescaler field, and a parameter sets the prescaler field to either 2 or 3 bits.

The generator pulls SCL low or releases it, in the manner of an open-drain output. It emits one strobe in the middle of each low phase, where SDA may change, and one strobe in the middle of each high phase, where SDA is sampled. After SCL is released, the high-phase count does not start until the synchronised SCL line is seen high. A target that stretches the clock therefore lengthens the period instead of shortening the high time. The configuration word and the compensation count are captured when the enable rises. Any change while the generator is enabled is held off until the next start. Choosing the divider values for a target bus rate is left to the software that programs the block.

Top module: `scl_clock_gen`

## Requirements
- R1: While `enable` is low, the block is idle from the next clock on. In that state `scl_pull_low`, `ref_tick`, `sda_drive_stb` and `sda_sample_stb` are all 0. The same holds during reset.
- R2: With the default 3-bit prescaler, `div_cfg[2:0]` holds the prescale value C and `div_cfg[8:3]` holds the divider step S. With a 2-bit prescaler the fields move to `[1:0]` and `[7:1+1]`. Within a low or high phase, `ref_tick` is high for one clock in every C+1 clocks, and the first tick of a phase comes C clocks after the phase starts.
- R3: The nominal period is P = 20 + 8*S + K ticks, where K is `comp_ticks`. The low phase lasts L = floor(P/2)+1 ticks, so the low phase lasts exactly L*(C+1) clocks. The high count lasts H = P - L ticks.
- R4: When `enable` is sampled high while the block is idle, `scl_pull_low` is 1 from the next clock on.
- R5: After SCL is released, the high count starts only when `scl_in` has been seen high through a synchroniser of SYNC_STAGES flops. With SYNC_STAGES=2 and the line released at once, SCL stays released for 3 + H*(C+1) clocks. Holding `scl_in` low for M more clocks lengthens that time by exactly M.
- R6: Exactly one `sda_drive_stb` occurs in each low phase. It falls on the tick whose in-phase count is floor(L/2), which is clock floor(L/2)*(C+1)+C of the phase. It is never high while SCL is released.
- R7: Exactly one `sda_sample_stb` occurs in each released phase. It comes after the synchroniser wait, on the tick whose high count is floor(H/2). It occurs only while SCL is released and `scl_in` is high.
- R8: `div_cfg` and `comp_ticks` are captured on the clock that starts the generator. Changes made while the generator is enabled leave the timing unchanged until `enable` falls and rises again.
- R9: The extreme setting C=7, S=63, K=15 gives P=539, L=270 and H=269, and these hold exactly. A prescaler width other than 2 or 3, a zero synchroniser depth, or a zero compensation width stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master interface enable; a rising level starts SCL generation |
| div_cfg | input | 6+PRESC_W | Packed divider word, divider step above prescale |
| comp_ticks | input | COMP_W | Rise/fall compensation, in reference ticks |
| scl_in | input | 1 | Actual SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| ref_tick | output | 1 | Internal reference tick enable |
| sda_drive_stb | output | 1 | Mid-low strobe where SDA may change |
| sda_sample_stb | output | 1 | Mid-high strobe where SDA is sampled |

## Verification
Two events can land on the same clock edge: the start of generation and a write to the divider word. The bench drives a new `div_cfg`, a new `comp_ticks` and the rising `enable` on the same negative edge. It then requires the measured low length, tick count and strobe positions to match the new values. The opposite case is a write on the first clock after the start. It must leave both the running period and the following period at the old values. The other overlap is a stretch release against the synchroniser wait: the released length is judged as exactly M clocks longer than the unstretched figure.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   localparam int unsigned BASE_TICKS = 20;
   localparam int unsigned STEP_TICKS = 8;
   localparam int unsigned SCGD_W     = 6;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
   import scl_gen_pkg::*;
#(
   parameter int unsigned PRESC_W = 3,
   parameter int unsigned COMP_W  = 4,
   parameter int unsigned CNT_W   = 10,
   localparam int unsigned DIV_W  = SCGD_W + PRESC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DIV_W-1:0]   div_cfg,
   input  logic [COMP_W-1:0]  comp_ticks,
   output logic [PRESC_W-1:0] presc_q,
   output logic [CNT_W-1:0]   low_len_q,
   output logic [CNT_W-1:0]   high_len_q,
   output logic [CNT_W-1:0]   low_mid_q,
   output logic [CNT_W-1:0]   high_mid_q
);
   logic [PRESC_W-1:0] presc_f;
   logic [SCGD_W-1:0]  step_f;
   logic [CNT_W-1:0]   per_c;
   logic [CNT_W-1:0]   low_c;
   logic [CNT_W-1:0]   high_c;

   // field split: divider step always sits above the prescale field
   generate
      if (PRESC_W == 2) begin : g_narrow
         assign presc_f = div_cfg[1:0];
         assign step_f  = div_cfg[SCGD_W+1:2];
      end else begin : g_wide
         assign presc_f = div_cfg[2:0];
         assign step_f  = div_cfg[SCGD_W+2:3];
      end
   endgenerate

   always_comb begin
      per_c  = CNT_W'(BASE_TICKS) + (CNT_W'(step_f) << 3) + CNT_W'(comp_ticks);
      low_c  = (per_c >> 1) + CNT_W'(1);
      high_c = per_c - low_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q    <= '0;
         low_len_q  <= '0;
         high_len_q <= '0;
         low_mid_q  <= '0;
         high_mid_q <= '0;
      end else if (load) begin
         presc_q    <= presc_f;
         low_len_q  <= low_c;
         high_len_q <= high_c;
         low_mid_q  <= low_c >> 1;
         high_mid_q <= high_c >> 1;
      end
   end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int unsigned PRESC_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               restart,
   input  logic [PRESC_W-1:0] limit,
   output logic               tick
);
   logic [PRESC_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= '0;
      else if (!run || restart || pc_q == limit)
         pc_q <= '0;
      else
         pc_q <= pc_q + PRESC_W'(1);
   end

   assign tick = run && (pc_q == limit);
endmodule

// File: rtl/scl_level_sync.sv
module scl_level_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             scl_high,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   input  logic [CNT_W-1:0] low_mid,
   input  logic [CNT_W-1:0] high_mid,
   output logic             load,
   output logic             busy,
   output logic             go_high,
   output logic             pull_low,
   output logic             drv_stb,
   output logic             smp_stb
);
   scl_phase_e       ph_q, ph_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             low_end, high_end;

   assign low_end  = (cnt_q == low_len - CNT_W'(1));
   assign high_end = (cnt_q == high_len - CNT_W'(1));
   assign load     = enable && (ph_q == PH_IDLE);
   assign go_high  = enable && (ph_q == PH_WAIT) && scl_high;

   always_comb begin
      ph_n  = ph_q;
      cnt_n = cnt_q;
      if (!enable) begin
         ph_n  = PH_IDLE;
         cnt_n = '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               ph_n  = PH_LOW;
               cnt_n = '0;
            end
            PH_LOW: if (tick) begin
               if (low_end) begin
                  ph_n  = PH_WAIT;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt_q + CNT_W'(1);
               end
            end
            PH_WAIT: if (scl_high) begin
               ph_n  = PH_HIGH;
               cnt_n = '0;
            end
            PH_HIGH: if (tick) begin
               if (high_end) begin
                  ph_n  = PH_LOW;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt_q + CNT_W'(1);
               end
            end
            default: begin
               ph_n  = PH_IDLE;
               cnt_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_n;
         cnt_q <= cnt_n;
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign pull_low = (ph_q == PH_LOW);
   assign drv_stb  = (ph_q == PH_LOW)  && tick && (cnt_q == low_mid);
   assign smp_stb  = (ph_q == PH_HIGH) && tick && (cnt_q == high_mid);
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
   import scl_gen_pkg::*;
#(
   parameter int unsigned PRESC_W     = 3,
   parameter int unsigned COMP_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DIV_W      = SCGD_W + PRESC_W,
   localparam int unsigned MAX_PER    = BASE_TICKS + STEP_TICKS * ((1 << SCGD_W) - 1)
                                        + ((1 << COMP_W) - 1),
   localparam int unsigned CNT_W      = $clog2(MAX_PER + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DIV_W-1:0]  div_cfg,
   input  logic [COMP_W-1:0] comp_ticks,
   input  logic              scl_in,
   output logic              scl_pull_low,
   output logic              ref_tick,
   output logic              sda_drive_stb,
   output logic              sda_sample_stb
);
   generate
      if (PRESC_W < 2 || PRESC_W > 3) begin : g_bad_presc
         $error("scl_clock_gen: PRESC_W must be 2 or 3");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("scl_clock_gen: SYNC_STAGES must be at least 1");
      end
      if (COMP_W < 1 || COMP_W > 6) begin : g_bad_comp
         $error("scl_clock_gen: COMP_W must be 1 to 6");
      end
   endgenerate

   logic [PRESC_W-1:0] presc_q;
   logic [CNT_W-1:0]   low_len, high_len, low_mid, high_mid;
   logic               load, busy, go_high, scl_high;

   scl_cfg_latch #(
      .PRESC_W (PRESC_W),
      .COMP_W  (COMP_W),
      .CNT_W   (CNT_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .div_cfg    (div_cfg),
      .comp_ticks (comp_ticks),
      .presc_q    (presc_q),
      .low_len_q  (low_len),
      .high_len_q (high_len),
      .low_mid_q  (low_mid),
      .high_mid_q (high_mid)
   );

   scl_prescaler #(
      .PRESC_W (PRESC_W)
   ) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (go_high),
      .limit   (presc_q),
      .tick    (ref_tick)
   );

   scl_level_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scl_in),
      .dout  (scl_high)
   );

   scl_phase_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .tick     (ref_tick),
      .scl_high (scl_high),
      .low_len  (low_len),
      .high_len (high_len),
      .low_mid  (low_mid),
      .high_mid (high_mid),
      .load     (load),
      .busy     (busy),
      .go_high  (go_high),
      .pull_low (scl_pull_low),
      .drv_stb  (sda_drive_stb),
      .smp_stb  (sda_sample_stb)
   );
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_in,
   input logic scl_pull_low,
   input logic ref_tick,
   input logic sda_drive_stb,
   input logic sda_sample_stb
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_pull_low && !ref_tick && !sda_drive_stb && !sda_sample_stb)); // R1

   AST_START_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> scl_pull_low); // R4

   AST_RELEASE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_pull_low) |-> !sda_sample_stb); // R5

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sda_drive_stb && sda_sample_stb)); // R6

   AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_stb |-> scl_pull_low); // R6

   AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sda_sample_stb |-> (!scl_pull_low && scl_in)); // R7
endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .scl_in         (scl_in),
   .scl_pull_low   (scl_pull_low),
   .ref_tick       (ref_tick),
   .sda_drive_stb  (sda_drive_stb),
   .sda_sample_stb (sda_sample_stb)
);

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;
   localparam int PW = 3;
   localparam int CW = 4;
   localparam int SY = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [PW+5:0] div_cfg = '0;
   logic [CW-1:0] comp_ticks = '0;
   logic          stretch = 1'b1;
   logic          scl_in;
   logic          scl_pull_low, ref_tick, sda_drive_stb, sda_sample_stb;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_in = ~scl_pull_low & ~stretch;

   scl_clock_gen #(
      .PRESC_W     (PW),
      .COMP_W      (CW),
      .SYNC_STAGES (SY)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (enable),
      .div_cfg        (div_cfg),
      .comp_ticks     (comp_ticks),
      .scl_in         (scl_in),
      .scl_pull_low   (scl_pull_low),
      .ref_tick       (ref_tick),
      .sda_drive_stb  (sda_drive_stb),
      .sda_sample_stb (sda_sample_stb)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called on the first negedge of a low phase
   task automatic phase_low(input int c, input int l, input string req);
      int n = 0, ticks = 0, sidx = -1, scnt = 0;
      while (scl_pull_low) begin
         if (ref_tick) ticks++;
         if (sda_drive_stb) begin scnt++; sidx = n; end
         n++;
         @(negedge clk);
      end
      check(n == l * (c + 1), req, "R3 low length clocks", n, l * (c + 1));
      check(ticks == l, "R2", "ticks in low phase", ticks, l);
      check(scnt == 1, "R6", "drive strobes per low phase", scnt, 1);
      check(sidx == (l / 2) * (c + 1) + c, "R6", "drive strobe position", sidx,
            (l / 2) * (c + 1) + c);
   endtask

   // called on the first negedge of a released phase
   task automatic phase_high(input int c, input int h, input int m, input string req);
      int n = 0, sidx = -1, scnt = 0;
      while (!scl_pull_low) begin
         if (n == m) stretch = 1'b0;
         if (sda_sample_stb) begin scnt++; sidx = n; end
         n++;
         @(negedge clk);
      end
      stretch = 1'b1;
      check(n == SY + 1 + m + h * (c + 1), req, "R5 released length clocks", n,
            SY + 1 + m + h * (c + 1));
      check(scnt == 1, "R7", "sample strobes per high phase", scnt, 1);
      check(sidx == SY + 1 + m + (h / 2) * (c + 1) + c, "R7", "sample strobe position",
            sidx, SY + 1 + m + (h / 2) * (c + 1) + c);
   endtask

   task automatic start_run(input int c, input int s, input int k);
      enable = 1'b0;
      repeat (3) @(negedge clk);
      div_cfg    = {6'(s), 3'(c)};
      comp_ticks = CW'(k);
      stretch    = 1'b1;
      enable     = 1'b1;
      @(negedge clk);
      check(scl_pull_low == 1'b1, "R4", "pull low after start", int'(scl_pull_low), 1);
   endtask

   task automatic run_case(input int c, input int s, input int k, input int m,
                           input string req);
      int p = 20 + 8 * s + k;
      int l = p / 2 + 1;
      int h = p - l;
      start_run(c, s, k);
      phase_low(c, l, req);
      phase_high(c, h, m, req);
      phase_low(c, l, req);
      enable = 1'b0;
   endtask

   task automatic test_reset();
      check(scl_pull_low == 1'b0 && ref_tick == 1'b0 && sda_drive_stb == 1'b0 &&
            sda_sample_stb == 1'b0, "R1", "outputs quiet in reset",
            int'({scl_pull_low, ref_tick, sda_drive_stb, sda_sample_stb}), 0);
   endtask

   task automatic test_latch();
      // start with 20-tick period, then rewrite the word one clock later
      start_run(0, 0, 0);
      div_cfg    = {6'd10, 3'd1};
      comp_ticks = CW'(7);
      phase_low(0, 11, "R8");
      phase_high(0, 9, 0, "R8");
      phase_low(0, 11, "R8");
      enable = 1'b0;
      // restart picks up the new word: P = 20 + 80 + 7 = 107, L = 54, H = 53
      run_case(1, 10, 7, 0, "R8");
   endtask

   task automatic test_disable();
      int bad = 0;
      start_run(1, 2, 1);
      repeat (7) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(scl_pull_low == 1'b0, "R1", "released after disable", int'(scl_pull_low), 0);
      for (int i = 0; i < 40; i++) begin
         if (scl_pull_low || ref_tick || sda_drive_stb || sda_sample_stb) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R1", "active cycles while disabled", bad, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_case(0, 0, 0, 0, "R3");      // P=20  L=11  H=9
      run_case(2, 3, 3, 0, "R2");      // P=47  L=24  H=23
      run_case(5, 1, 2, 10, "R5");     // P=30  L=16  H=14, stretched 10
      run_case(0, 4, 0, 37, "R5");     // P=52  L=27  H=25, stretched 37
      run_case(7, 63, 15, 0, "R9");    // P=539 L=270 H=269
      test_latch();
      test_disable();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule